// File: doc/BRIEF.md
# Counted-Source Interrupt Dispatcher

This block sits between a set of interrupt sources and a downstream interrupt controller. It decides when each of its input pins turns into a delivery message. It keeps a routing entry for each pin, holding a mask, a trigger level, a vector, a destination, an addressing flag and a delivery mode. It also keeps a signed assertion count per pin.

Sources do not drive wires. They send commands that raise, lower or pulse the count. A message goes out only when an assert takes a pin's count from zero to one. Level-triggered pins are flow-controlled by a remote-pending bit. Sending a level pin sets the bit. An end-of-interrupt for the matching vector clears it, and the pin is sent again if it is still asserted. Rewriting a routing entry also re-evaluates that pin.

All work enters through a single valid/ready request channel, so operations are strictly serialized. Messages leave through a one-deep valid/ready output register. Back-pressure rules:
- `req_ready` is low while a message waits in the output register or while an end-of-interrupt walk is in progress.
- An offered message stays stable until it is accepted.
- The walk advances one pin per cycle, and it pauses whenever the output register is full.

Top module: `irq_dispatch`

## Requirements
- R1: A pin's count rises by one on an accepted assert (op 0). It falls by one on a deassert (op 1). A pulse (op 2) behaves as an assert then a deassert, so the count is unchanged overall.
- R2: An assert or pulse sends a message only when the pin's count was exactly zero beforehand. A deassert, or any other count change, never sends.
- R3: When a command would leave the count negative, `cnt_err` is high for one cycle, in the cycle after acceptance, and no message is sent. A pulse on a negative count counts as such a command.
- R4: A pin whose entry has the mask bit set never produces a message.
- R5: A message carries the pin index and the entry's vector, destination, addressing flag, mode and trigger level. The message appears the cycle after the request is accepted.
- R6: Sending a level-triggered pin sets that pin's remote-pending bit. Sending an edge-triggered pin leaves the bit unchanged. Remote-pending is kept across routing writes.
- R7: An end-of-interrupt (op 3, vector on `req_vector`) walks the pins in ascending order. For each pin that has remote-pending set and a matching vector, it clears the bit and resends the pin if its count is above zero and it is unmasked. `eoi_busy` is high for the whole walk.
- R8: A routing write (op 4) replaces the pin's entry. After the write, the pin is sent if it is unmasked, its remote-pending bit is clear and its count is above zero.
- R9: An assert, deassert, pulse or routing write whose pin index is 32 or more changes no state and produces neither a message nor `cnt_err`.
- R10: While `msg_valid` is high and `msg_ready` is low, the message fields hold steady. `req_ready` is low whenever `msg_valid` or `eoi_busy` is high.
- R11: After reset every entry is masked, every count is zero, every remote-pending bit is clear, and no message or walk is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | 0 assert, 1 deassert, 2 pulse, 3 end-of-interrupt, 4 routing write; 5-7 no effect |
| req_pin | input | 6 | Pin index (unused by end-of-interrupt) |
| req_vector | input | 8 | End-of-interrupt vector, or vector for a routing write |
| req_mask | input | 1 | Routing write: mask bit |
| req_level | input | 1 | Routing write: 1 level-triggered, 0 edge |
| req_phys | input | 1 | Routing write: 1 physical addressing, 0 logical |
| req_mode | input | 3 | Routing write: delivery mode |
| req_dest | input | 8 | Routing write: destination |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Downstream accepts message |
| msg_pin | output | 5 | Pin that produced the message |
| msg_vector | output | 8 | Vector |
| msg_dest | output | 8 | Destination |
| msg_phys | output | 1 | Addressing flag |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Trigger level |
| cnt_err | output | 1 | One-cycle flag for a negative count |
| eoi_busy | output | 1 | End-of-interrupt walk in progress |

## Verification
The assertions take for granted that `req_op`, `req_pin` and the routing fields are stable while `req_valid` is high. They also assume that a downstream consumer may hold `msg_ready` low for any number of cycles. The stimulus offers each request at a falling edge, removes it right after it is taken, and keeps every pin's count well inside the signed counter range so that wrap-around never occurs. Vectors are drawn from a small pool so that end-of-interrupt walks regularly match several pins. `msg_ready` is randomized during walks and held low on purpose after commands so that stalls are exercised.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    OP_ASSERT   = 3'd0,
    OP_DEASSERT = 3'd1,
    OP_PULSE    = 3'd2,
    OP_EOI      = 3'd3,
    OP_ROUTE    = 3'd4
  } op_e;

  typedef struct packed {
    logic              mask;
    logic              level;
    logic              phys;
    logic [MODE_W-1:0] mode;
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vector;
  } route_t;

  localparam route_t ROUTE_RESET = route_t'{1'b1, 1'b0, 1'b0, '0, '0, '0};
endpackage

// File: rtl/irq_count_bank.sv
module irq_count_bank #(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 6,
  parameter int IDX_W    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [CNT_W-1:0]                   wr_val,
  output logic [NUM_PINS-1:0][CNT_W-1:0]     cnt
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        cnt[g] <= wr_val;
    end
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int IDX_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  route_t                     wr_entry,
  input  logic                       rp_set,
  input  logic [IDX_W-1:0]           rp_set_idx,
  input  logic                       rp_clr,
  input  logic [IDX_W-1:0]           rp_clr_idx,
  output route_t [NUM_PINS-1:0]      entries,
  output logic   [NUM_PINS-1:0]      rp
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        entries[g] <= ROUTE_RESET;
      else if (wr_en && wr_idx == IDX_W'(g))
        entries[g] <= wr_entry;
    end

    // a set in the same cycle as a clear wins: the resend re-arms the pin
    always_ff @(posedge clk) begin
      if (!rst_n)
        rp[g] <= 1'b0;
      else if (rp_set && rp_set_idx == IDX_W'(g))
        rp[g] <= 1'b1;
      else if (rp_clr && rp_clr_idx == IDX_W'(g))
        rp[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_eoi_scan.sv
module irq_eoi_scan #(
  parameter int NUM_PINS = 32,
  parameter int IDX_W    = 5,
  parameter int VEC_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] start_vec,
  input  logic             step,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PINS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      vec  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      vec  <= start_vec;
    end else if (step && busy) begin
      if (idx == LAST)
        busy <= 1'b0;
      else
        idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 6,
  localparam int IDX_W   = $clog2(NUM_PINS),
  localparam int PIN_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [PIN_W-1:0]  req_pin,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              req_mask,
  input  logic              req_level,
  input  logic              req_phys,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DEST_W-1:0] req_dest,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [IDX_W-1:0]  msg_pin,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [DEST_W-1:0] msg_dest,
  output logic              msg_phys,
  output logic [MODE_W-1:0] msg_mode,
  output logic              msg_level,
  output logic              cnt_err,
  output logic              eoi_busy
);
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_PINS-1:0][CNT_W-1:0] cnt_flat;
  route_t [NUM_PINS-1:0]          entries;
  logic   [NUM_PINS-1:0]          rp;

  logic                     cnt_we;
  logic [IDX_W-1:0]         cnt_idx;
  logic signed [CNT_W-1:0]  cnt_val;
  logic                     rt_we;
  route_t                   new_entry;
  logic                     rp_set, rp_clr;
  logic [IDX_W-1:0]         rp_set_idx, rp_clr_idx;
  logic                     send;
  logic [IDX_W-1:0]         send_idx;
  route_t                   send_entry;
  logic                     err_d;
  logic                     scan_start, scan_step;
  logic [IDX_W-1:0]         scan_idx;
  logic [VEC_W-1:0]         scan_vec;

  logic                     accept, pin_ok;
  logic [IDX_W-1:0]         ridx;
  logic signed [CNT_W-1:0]  cur, scan_cnt, cnt_inc, cnt_dec;

  assign req_ready = !msg_valid && !eoi_busy;
  assign accept    = req_valid && req_ready;
  assign pin_ok    = req_pin < PIN_W'(NUM_PINS);
  assign ridx      = req_pin[IDX_W-1:0];
  assign cur       = $signed(cnt_flat[ridx]);
  assign cnt_inc   = cur + ONE;
  assign cnt_dec   = cur - ONE;
  assign scan_cnt  = $signed(cnt_flat[scan_idx]);
  assign scan_step = eoi_busy && !msg_valid;
  assign new_entry = route_t'{req_mask, req_level, req_phys, req_mode, req_dest, req_vector};

  irq_count_bank #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
    .clk, .rst_n, .wr_en(cnt_we), .wr_idx(cnt_idx), .wr_val(cnt_val), .cnt(cnt_flat)
  );

  irq_route_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_rt (
    .clk, .rst_n, .wr_en(rt_we), .wr_idx(ridx), .wr_entry(new_entry),
    .rp_set, .rp_set_idx, .rp_clr, .rp_clr_idx, .entries, .rp
  );

  irq_eoi_scan #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_scan (
    .clk, .rst_n, .start(scan_start), .start_vec(req_vector), .step(scan_step),
    .busy(eoi_busy), .idx(scan_idx), .vec(scan_vec)
  );

  always_comb begin
    cnt_we     = 1'b0;
    cnt_idx    = ridx;
    cnt_val    = cur;
    rt_we      = 1'b0;
    rp_clr     = 1'b0;
    rp_clr_idx = scan_idx;
    send       = 1'b0;
    send_idx   = ridx;
    send_entry = entries[ridx];
    err_d      = 1'b0;
    scan_start = 1'b0;
    if (accept) begin
      unique case (req_op)
        OP_ASSERT: if (pin_ok) begin
          cnt_we  = 1'b1;
          cnt_val = cnt_inc;
          err_d   = cnt_inc[CNT_W-1];
          send    = (cur == '0) && !entries[ridx].mask;
        end
        OP_DEASSERT: if (pin_ok) begin
          cnt_we  = 1'b1;
          cnt_val = cnt_dec;
          err_d   = cnt_dec[CNT_W-1];
        end
        OP_PULSE: if (pin_ok) begin
          err_d = cur[CNT_W-1];
          send  = (cur == '0) && !entries[ridx].mask;
        end
        OP_EOI: scan_start = 1'b1;
        OP_ROUTE: if (pin_ok) begin
          rt_we      = 1'b1;
          send_entry = new_entry;
          send       = !req_mask && !rp[ridx] && !cur[CNT_W-1] && (cur != '0);
        end
        default: ;
      endcase
    end else if (scan_step) begin
      send_idx   = scan_idx;
      send_entry = entries[scan_idx];
      if (rp[scan_idx] && entries[scan_idx].vector == scan_vec) begin
        rp_clr = 1'b1;
        send   = !scan_cnt[CNT_W-1] && (scan_cnt != '0) && !entries[scan_idx].mask;
      end
    end
    rp_set     = send && send_entry.level;
    rp_set_idx = send_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_pin    <= '0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_phys   <= 1'b0;
      msg_mode   <= '0;
      msg_level  <= 1'b0;
      cnt_err    <= 1'b0;
    end else begin
      cnt_err <= err_d;
      if (send) begin
        msg_valid  <= 1'b1;
        msg_pin    <= send_idx;
        msg_vector <= send_entry.vector;
        msg_dest   <= send_entry.dest;
        msg_phys   <= send_entry.phys;
        msg_mode   <= send_entry.mode;
        msg_level  <= send_entry.level;
      end else if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W   = $clog2(NUM_PINS),
  localparam int PIN_W   = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [PIN_W-1:0]  req_pin,
  input logic [VEC_W-1:0]  req_vector,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [IDX_W-1:0]  msg_pin,
  input logic [VEC_W-1:0]  msg_vector,
  input logic [DEST_W-1:0] msg_dest,
  input logic              msg_phys,
  input logic [MODE_W-1:0] msg_mode,
  input logic              msg_level,
  input logic              cnt_err,
  input logic              eoi_busy
);
  logic taken;
  assign taken = req_valid && req_ready;

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid &&
      $stable({msg_pin, msg_vector, msg_dest, msg_phys, msg_mode, msg_level}));

  // R10
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid || eoi_busy) |-> !req_ready);

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> !msg_valid);

  // R9
  bad_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_op != OP_EOI && req_op <= OP_ROUTE && req_pin >= PIN_W'(NUM_PINS)
      |=> !msg_valid && !cnt_err);

  // R2
  deassert_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_op == OP_DEASSERT |=> !msg_valid);

  // R7
  eoi_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_op == OP_EOI |=> eoi_busy && !msg_valid);
endmodule

bind irq_dispatch irq_dispatch_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [5:0] req_pin = '0;
  logic [7:0] req_vector = '0, req_dest = '0;
  logic req_mask = 1'b0, req_level = 1'b0, req_phys = 1'b0;
  logic [2:0] req_mode = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [4:0] msg_pin;
  logic [7:0] msg_vector, msg_dest;
  logic msg_phys, msg_level, cnt_err, eoi_busy;
  logic [2:0] msg_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch u_irq_dispatch (.*);

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int cnt_m[NP];
  bit rp_m[NP], msk_m[NP], lvl_m[NP], phy_m[NP];
  int vec_m[NP], dst_m[NP], mod_m[NP];

  function automatic logic [31:0] pk(int pin, int vec, int dest, bit phy, int mode, bit lvl);
    return {6'd0, pin[4:0], lvl, phy, mode[2:0], dest[7:0], vec[7:0]};
  endfunction

  function automatic logic [31:0] pk_out();
    return pk(int'(msg_pin), int'(msg_vector), int'(msg_dest), msg_phys, int'(msg_mode), msg_level);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // hold a pending message for a while, then accept it
  task automatic drain();
    logic [31:0] held;
    if (!msg_valid) return;
    held = pk_out();
    @(negedge clk);
    check(msg_valid && pk_out() == held && !req_ready, "R10 stall hold", pk_out(), held);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    check(!msg_valid, "R10 release", msg_valid, 0);
  endtask

  task automatic issue(input int op, input int pin, input int vec, input bit msk,
                       input bit lvl, input bit phy, input int mode, input int dest);
    bit exp_send = 0, exp_err = 0;
    logic [31:0] exp_msg = '0;
    string tag;
    int old;
    @(negedge clk);
    tag = (pin >= NP) ? "R9" : "R2";
    if (pin < NP) begin
      old = cnt_m[pin];
      case (op)
        0: begin cnt_m[pin]++; exp_err = cnt_m[pin] < 0; exp_send = old == 0 && !msk_m[pin]; end
        1: begin cnt_m[pin]--; exp_err = cnt_m[pin] < 0; end
        2: begin exp_err = old < 0; exp_send = old == 0 && !msk_m[pin]; end
        4: begin
          msk_m[pin] = msk; lvl_m[pin] = lvl; phy_m[pin] = phy;
          vec_m[pin] = vec; dst_m[pin] = dest; mod_m[pin] = mode;
          exp_send = !msk && !rp_m[pin] && old > 0; tag = "R8";
        end
        default: ;
      endcase
      if (op != 4 && msk_m[pin]) tag = "R4";
      if (exp_send) begin
        exp_msg = pk(pin, vec_m[pin], dst_m[pin], phy_m[pin], mod_m[pin], lvl_m[pin]);
        if (lvl_m[pin]) rp_m[pin] = 1'b1;
      end
    end
    req_op = 3'(op); req_pin = 6'(pin); req_vector = 8'(vec); req_mask = msk;
    req_level = lvl; req_phys = phy; req_mode = 3'(mode); req_dest = 8'(dest);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(msg_valid == exp_send, tag, msg_valid, exp_send);
    if (exp_send && msg_valid) check(pk_out() == exp_msg, "R5 fields", pk_out(), exp_msg);
    check(cnt_err == exp_err, exp_err ? "R3" : "R3 no flag", cnt_err, exp_err);
    drain();
  endtask

  task automatic eoi(input int vec);
    logic [31:0] exp_q[NP];
    int exp_n = 0, got = 0, guard = 0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (rp_m[p] && vec_m[p] == vec) begin
        rp_m[p] = 1'b0;
        if (cnt_m[p] > 0 && !msk_m[p]) begin
          exp_q[exp_n] = pk(p, vec_m[p], dst_m[p], phy_m[p], mod_m[p], lvl_m[p]);
          exp_n++;
          if (lvl_m[p]) rp_m[p] = 1'b1;
        end
      end
    end
    req_op = 3'd3; req_vector = 8'(vec); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(eoi_busy, "R7 busy", eoi_busy, 1);
    while ((eoi_busy || msg_valid) && guard < 2000) begin
      guard++;
      msg_ready = 1'b0;
      if (msg_valid) begin
        if (got < exp_n) check(pk_out() == exp_q[got], "R7 resend", pk_out(), exp_q[got]);
        else check(0, "R7 extra message", pk_out(), 0);
        msg_ready = 1'($urandom % 2);
        if (msg_ready) got++;
      end
      @(negedge clk);
    end
    msg_ready = 1'b0;
    check(got == exp_n, "R7 count", got, exp_n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) begin
      cnt_m[p] = 0; rp_m[p] = 0; msk_m[p] = 1; lvl_m[p] = 0; phy_m[p] = 0;
      vec_m[p] = 0; dst_m[p] = 0; mod_m[p] = 0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!msg_valid && req_ready && !eoi_busy && !cnt_err, "R11 reset outputs",
          {msg_valid, req_ready, eoi_busy, cnt_err}, 4'b0100);
    issue(0, 3, 0, 0, 0, 0, 0, 0);              // R11 masked after reset
    issue(1, 3, 0, 0, 0, 0, 0, 0);
    // level pin 5
    issue(4, 5, 8'h41, 0, 1, 1, 3, 8'hA5);      // count 0: no send
    issue(0, 5, 0, 0, 0, 0, 0, 0);              // 0->1 sends, sets remote-pending
    issue(0, 5, 0, 0, 0, 0, 0, 0);              // 1->2 silent
    issue(1, 5, 0, 0, 0, 0, 0, 0);
    issue(4, 5, 8'h41, 0, 1, 1, 3, 8'hA5);      // R6 pending kept: no send
    eoi(8'h42);
    eoi(8'h41);                                 // resend
    // R1: count bookkeeping seen through a routing re-check
    issue(0, 7, 0, 0, 0, 0, 0, 0);
    issue(0, 7, 0, 0, 0, 0, 0, 0);
    issue(1, 7, 0, 0, 0, 0, 0, 0);
    issue(2, 7, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    issue(4, 7, 8'h22, 0, 0, 0, 1, 8'h0F);      // count 1 -> edge send
    issue(4, 7, 8'h22, 0, 0, 0, 1, 8'h0F);      // edge: no pending, sends again (R1/R6)
    // R9 out-of-range pins alias pin 8 in low bits
    issue(4, 8, 8'h30, 0, 0, 0, 0, 8'h01);
    issue(0, 40, 0, 0, 0, 0, 0, 0);
    issue(4, 40, 8'h31, 1, 0, 0, 0, 8'h02);
    issue(4, 8, 8'h30, 0, 0, 0, 0, 8'h01);      // count still 0: no send
    issue(0, 8, 0, 0, 0, 0, 0, 0);              // sends with pin 8 entry
    // R3 negative counts
    issue(1, 9, 0, 0, 0, 0, 0, 0);
    issue(2, 9, 0, 0, 0, 0, 0, 0);
    issue(0, 9, 0, 0, 0, 0, 0, 0);              // -1 -> 0 silent
    issue(2, 9, 0, 0, 0, 0, 0, 0);              // pulse at 0, masked
    // random mix
    for (int i = 0; i < 500; i++) begin
      int r, pin, op;
      r = $urandom % 100;
      pin = (($urandom % 10) == 0) ? 32 + $urandom % 32 : $urandom % NP;
      if (r < 10) eoi(8'h40 + $urandom % 4);
      else begin
        op = (r < 35) ? 0 : (r < 60) ? 1 : (r < 75) ? 2 : 4;
        if (pin < NP && op == 0 && cnt_m[pin] > 10) op = 1;
        if (pin < NP && op == 1 && cnt_m[pin] < -10) op = 0;
        issue(op, pin, 8'h40 + $urandom % 4, ($urandom % 4) == 0, 1'($urandom % 2),
              1'($urandom % 2), $urandom % 8, $urandom % 256);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule